// File: doc/BRIEF.md
# I2C Byte FIFO and Interrupt Controller

This block sits between a register bus and an I2C serial engine. It holds one byte queue for each direction. The host fills the transmit queue and the engine drains it. The engine fills the receive queue and the host drains it. Each queue has its own enable and its own trigger level. A packed status word reports the fill level and the full and empty flags of both queues.

An interrupt status word collects two kinds of bit. Two are live threshold indications. The other ten are sticky events: pushes into a full queue, pops from an empty queue, a receive-idle (trailing) timeout, and five transfer-outcome pulses from the engine. A sticky bit is cleared by writing a one to it. A mask selects which status bits drive the single interrupt line. A soft reset input empties both queues and clears all sticky state.

Queue depth is set by the `DEPTH` parameter and must be 16 or 64. The engine is represented only by its byte push and pop ports and its outcome pulses.

Top module: `i2c_fifo_irq`

## Requirements
- R1: Control word `fifo_ctl` uses bit 0 to enable the RX queue, bit 1 to enable the TX queue, bits [4 +: LW] for the RX trigger and bits [16 +: LW] for the TX trigger, where LW = log2(DEPTH)+1. A disabled queue is held empty and ignores pushes and pops without raising any flag.
- R2: `fifo_stat` packs the TX level in [6:0], TX full at 7, TX empty at 8, the RX level in [22:16], RX full at 23 and RX empty at 24. All other bits are 0.
- R3: Each queue returns bytes in the order they were written and holds at most DEPTH bytes. The full flag is set exactly at DEPTH.
- R4: A push into a full queue (with no pop in the same cycle) drops the byte, leaves the level unchanged and sets the overrun bit: TX overrun is status bit 3, RX overrun is status bit 5.
- R5: A pop from an empty enabled queue returns 0 and sets the underrun bit: TX underrun is status bit 2, RX underrun is status bit 4.
- R6: Status bit 0 reads 1 while TX is enabled and the TX level is at or below the TX trigger. Status bit 1 reads 1 while RX is enabled and the RX level is at or above the RX trigger. Both bits follow the level and cannot be cleared by a write.
- R7: Status bit 6 is set when the RX queue holds data and no byte has been pushed for trail_thr+1 consecutive cycles after the last push.
- R8: Input pulses set sticky bits: done at bit 7, abort at 8, no-ack at 9, no device at 10, timeout at 11.
- R9: With `clr_we` high, each one in `clr_bits` clears the matching sticky bit and leaves the others alone. An event arriving in the same cycle wins over the clear.
- R10: `irq` is high exactly when some bit is set in both `int_stat` and `int_mask`.
- R11: A cycle with `soft_rst` high empties both queues and clears every sticky bit.
- R12: After `rst_n` is released, both queues are empty and every sticky bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous flush of queues and sticky status |
| fifo_ctl | input | 16+LW | Queue enables and trigger levels |
| trail_thr | input | 4 | Receive idle count for the trailing interrupt |
| int_mask | input | 12 | Interrupt enable mask |
| clr_we | input | 1 | Write strobe for the status clear |
| clr_bits | input | 12 | Write-one-to-clear pattern |
| host_wr | input | 1 | Host push into TX queue |
| host_wdata | input | 8 | Host TX byte |
| host_rd | input | 1 | Host pop from RX queue |
| host_rdata | output | 8 | Head of RX queue, 0 when empty |
| eng_tx_pop | input | 1 | Engine pop from TX queue |
| eng_tx_data | output | 8 | Head of TX queue, 0 when empty |
| eng_rx_push | input | 1 | Engine push into RX queue |
| eng_rx_data | input | 8 | Engine RX byte |
| ev_done | input | 1 | Transfer complete pulse |
| ev_abort | input | 1 | Arbitration loss pulse |
| ev_nack | input | 1 | Missing acknowledge pulse |
| ev_nodev | input | 1 | Missing device pulse |
| ev_tmo | input | 1 | Bus timeout pulse |
| fifo_stat | output | 25 | Queue levels and flags |
| int_stat | output | 12 | Interrupt status |
| irq | output | 1 | Interrupt line |

## Verification
The bench fills the TX queue to the brim and then pushes once more. A design that stored the extra byte would overwrite the oldest byte and corrupt the drained sequence. It would also leave the overrun flag clear. The bench pops an empty queue from each side, which exposes stale head data or a missing underrun flag. It walks the TX level through its trigger one step at a time to catch an off-by-one comparison in either threshold. It times the trailing bit cycle by cycle: a counter that starts or compares one step late raises the bit a cycle off. The bench also clears and sets the same sticky bit in one cycle, and clears one bit while others are set. These two cases catch a clear that beats a new event or a clear that wipes neighbouring bits. Finally, it pushes with a queue disabled to confirm that no data is stored and no flag is raised.

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic [16+LW-1:0] fifo_ctl,
  input  logic [3:0]      trail_thr,
  input  logic [11:0]     int_mask,
  input  logic            clr_we,
  input  logic [11:0]     clr_bits,
  input  logic            host_wr,
  input  logic [7:0]      host_wdata,
  input  logic            host_rd,
  output logic [7:0]      host_rdata,
  input  logic            eng_tx_pop,
  output logic [7:0]      eng_tx_data,
  input  logic            eng_rx_push,
  input  logic [7:0]      eng_rx_data,
  input  logic            ev_done,
  input  logic            ev_abort,
  input  logic            ev_nack,
  input  logic            ev_nodev,
  input  logic            ev_tmo,
  output logic [24:0]     fifo_stat,
  output logic [11:0]     int_stat,
  output logic            irq
);

  logic [7:0]    txm [DEPTH];
  logic [7:0]    rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;
  logic [11:2]   sticky;
  logic [3:0]    idle;

  wire rx_on = fifo_ctl[0];
  wire tx_on = fifo_ctl[1];
  wire [LW-1:0] rx_trig = fifo_ctl[4 +: LW];
  wire [LW-1:0] tx_trig = fifo_ctl[16 +: LW];

  logic unused_ctl;
  assign unused_ctl = ^{fifo_ctl[3:2], fifo_ctl[15:4+LW], clr_bits[1:0]};

  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == LW'(DEPTH));
  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == LW'(DEPTH));

  wire tx_pop_ok  = tx_on && eng_tx_pop && !tx_empty;
  wire tx_push_ok = tx_on && host_wr && (!tx_full || eng_tx_pop);
  wire tx_ovr     = tx_on && host_wr && tx_full && !eng_tx_pop;
  wire tx_udr     = tx_on && eng_tx_pop && tx_empty;

  wire rx_pop_ok  = rx_on && host_rd && !rx_empty;
  wire rx_push_ok = rx_on && eng_rx_push && (!rx_full || host_rd);
  wire rx_ovr     = rx_on && eng_rx_push && rx_full && !host_rd;
  wire rx_udr     = rx_on && host_rd && rx_empty;

  wire trail_hit = rx_on && !rx_empty && !rx_push_ok && (idle == trail_thr);

  assign eng_tx_data = tx_empty ? 8'h00 : txm[tx_rp];
  assign host_rdata  = rx_empty ? 8'h00 : rxm[rx_rp];

  always_ff @(posedge clk) begin
    if (tx_push_ok) txm[tx_wp] <= host_wdata;
    if (rx_push_ok) rxm[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (soft_rst || !tx_on) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push_ok) tx_wp <= tx_wp + 1'b1;
      if (tx_pop_ok)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + LW'(tx_push_ok) - LW'(tx_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (soft_rst || !rx_on) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push_ok) rx_wp <= rx_wp + 1'b1;
      if (rx_pop_ok)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + LW'(rx_push_ok) - LW'(rx_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle <= '0;
    else if (soft_rst || !rx_on || rx_push_ok || rx_empty)
      idle <= '0;
    else if (idle != 4'hF)
      idle <= idle + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sticky <= '0;
    else if (soft_rst)
      sticky <= '0;
    else
      sticky <= (sticky & ~(clr_we ? clr_bits[11:2] : 10'd0))
              | {ev_tmo, ev_nodev, ev_nack, ev_abort, ev_done,
                 trail_hit, rx_ovr, rx_udr, tx_ovr, tx_udr};
  end

  assign int_stat  = {sticky, rx_on && (rx_cnt >= rx_trig), tx_on && (tx_cnt <= tx_trig)};
  assign irq       = |(int_stat & int_mask);
  assign fifo_stat = {rx_empty, rx_full, 7'(rx_cnt), 7'd0, tx_empty, tx_full, 7'(tx_cnt)};

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= LW'(DEPTH)) && (rx_cnt <= LW'(DEPTH))); // R3
  AST_TX_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr && !soft_rst) |=> (int_stat[3] && $stable(tx_cnt))); // R4
  AST_RX_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !soft_rst) |=> (int_stat[5] && $stable(rx_cnt))); // R4
  AST_UDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && host_rd && fifo_stat[24]) |-> (host_rdata == 8'h00)); // R5
  AST_TRAIL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stat[6]) |-> ($past(rx_cnt) != '0)); // R7
  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[7] && !ev_done) |=> !int_stat[7]); // R9
  AST_SOFT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (fifo_stat[8] && fifo_stat[24] && (int_stat[11:2] == '0))); // R11

endmodule

// File: tb/sim_i2c_fifo_irq.sv
module sim_i2c_fifo_irq;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic [16+LW-1:0] fifo_ctl = '0;
  logic [3:0] trail_thr = 4'd0;
  logic [11:0] int_mask = '0, clr_bits = '0;
  logic clr_we = 1'b0, host_wr = 1'b0, host_rd = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0] host_wdata = '0, eng_rx_data = '0;
  logic [4:0] ev = '0;
  logic [7:0] host_rdata, eng_tx_data;
  logic [24:0] fifo_stat;
  logic [11:0] int_stat;
  logic irq;

  int checks = 0, fails = 0;

  i2c_fifo_irq #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .fifo_ctl(fifo_ctl),
    .trail_thr(trail_thr), .int_mask(int_mask), .clr_we(clr_we), .clr_bits(clr_bits),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .ev_done(ev[0]), .ev_abort(ev[1]), .ev_nack(ev[2]),
    .ev_nodev(ev[3]), .ev_tmo(ev[4]), .fifo_stat(fifo_stat), .int_stat(int_stat), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [16+LW-1:0] cfg(bit rxe, bit txe, int rxt, int txt);
    logic [16+LW-1:0] v = '0;
    v[0] = rxe;
    v[1] = txe;
    v[4 +: LW] = LW'(rxt);
    v[16 +: LW] = LW'(txt);
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic clr_all;
    clr_we = 1'b1; clr_bits = 12'hFFF; tick(); clr_we = 1'b0; clr_bits = '0;
  endtask

  task automatic t_reset;
    chk("R12 fifo_stat after reset", 32'(fifo_stat), 32'h0100_0100);
    chk("R12 int_stat after reset", 32'(int_stat), 0);
    chk("R12 irq after reset", 32'(irq), 0);
  endtask

  task automatic t_disabled;
    fifo_ctl = '0;
    host_wr = 1'b1; host_wdata = 8'h55; eng_rx_push = 1'b1; eng_rx_data = 8'h66;
    tick();
    host_wr = 1'b0; eng_rx_push = 1'b0;
    chk("R1 disabled TX keeps level 0", 32'(fifo_stat[6:0]), 0);
    chk("R1 disabled RX keeps level 0", 32'(fifo_stat[22:16]), 0);
    chk("R1 disabled queues raise no flag", 32'(int_stat), 0);
    fifo_ctl = cfg(0, 1, 0, 0); #1;
    chk("R1 TX enable bit drives almost-empty", 32'(int_stat[0]), 1);
    fifo_ctl = '0; #1;
  endtask

  task automatic t_tx;
    clr_all();
    fifo_ctl = cfg(0, 1, 0, 4);
    for (int i = 0; i < DEPTH; i++) begin
      host_wr = 1'b1; host_wdata = 8'(i * 7 + 3); tick();
    end
    host_wr = 1'b0;
    chk("R2 TX level field", 32'(fifo_stat[6:0]), DEPTH);
    chk("R3 TX full flag at depth", 32'(fifo_stat[8:7]), 32'b01);
    chk("R6 almost-empty low above trigger", 32'(int_stat[0]), 0);
    host_wr = 1'b1; host_wdata = 8'hEE; tick(); host_wr = 1'b0;
    chk("R4 TX overrun bit 3", 32'(int_stat[3]), 1);
    chk("R4 TX level unchanged on overrun", 32'(fifo_stat[6:0]), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      eng_tx_pop = 1'b1; #1;
      chk("R3 TX order", 32'(eng_tx_data), 32'(8'(i * 7 + 3)));
      tick();
      if (i == DEPTH - 6) chk("R6 almost-empty low at trigger+1", 32'(int_stat[0]), 0);
      if (i == DEPTH - 5) chk("R6 almost-empty high at trigger", 32'(int_stat[0]), 1);
    end
    eng_tx_pop = 1'b0;
    chk("R2 TX empty flag", 32'(fifo_stat[8:0]), 32'h100);
    eng_tx_pop = 1'b1; #1;
    chk("R5 TX pop when empty returns 0", 32'(eng_tx_data), 0);
    tick(); eng_tx_pop = 1'b0;
    chk("R5 TX underrun bit 2", 32'(int_stat[2]), 1);
  endtask

  task automatic t_rx;
    clr_all();
    fifo_ctl = cfg(1, 0, 3, 0); #1;
    chk("R6 almost-full low when empty", 32'(int_stat[1]), 0);
    for (int i = 0; i < 3; i++) begin
      eng_rx_push = 1'b1; eng_rx_data = 8'(8'hA0 + i); tick();
      if (i == 1) chk("R6 almost-full low below trigger", 32'(int_stat[1]), 0);
    end
    eng_rx_push = 1'b0;
    chk("R6 almost-full high at trigger", 32'(int_stat[1]), 1);
    chk("R2 RX level field", 32'(fifo_stat[22:16]), 3);
    for (int i = 0; i < 3; i++) begin
      host_rd = 1'b1; #1;
      chk("R3 RX order", 32'(host_rdata), 32'(8'hA0 + i));
      tick();
    end
    #1;
    chk("R5 RX read when empty returns 0", 32'(host_rdata), 0);
    tick(); host_rd = 1'b0;
    chk("R5 RX underrun bit 4", 32'(int_stat[4]), 1);
    for (int i = 0; i <= DEPTH; i++) begin
      eng_rx_push = 1'b1; eng_rx_data = 8'(i); tick();
    end
    eng_rx_push = 1'b0;
    chk("R4 RX overrun bit 5", 32'(int_stat[5]), 1);
    chk("R2 RX full flag and level", 32'(fifo_stat[24:16]), 32'h080 | DEPTH);
    host_rd = 1'b1; #1;
    chk("R4 RX overrun kept oldest byte", 32'(host_rdata), 0);
    host_rd = 1'b0;
  endtask

  task automatic t_srst;
    soft_rst = 1'b1; tick(); soft_rst = 1'b0;
    chk("R11 soft reset empties queues", 32'(fifo_stat), 32'h0100_0100);
    chk("R11 soft reset clears status", 32'(int_stat), 0);
  endtask

  task automatic t_trail;
    clr_all();
    fifo_ctl = cfg(1, 0, 15, 0); trail_thr = 4'd3;
    eng_rx_push = 1'b1; eng_rx_data = 8'h42; tick(); eng_rx_push = 1'b0;
    tick(); tick(); tick();
    chk("R7 trailing not yet set after thr cycles", 32'(int_stat[6]), 0);
    tick();
    chk("R7 trailing set after thr+1 idle cycles", 32'(int_stat[6]), 1);
  endtask

  task automatic t_irq;
    int_mask = 12'h040; #1;
    chk("R10 irq from enabled trailing bit", 32'(irq), 1);
    int_mask = 12'h008; #1;
    chk("R10 irq low when set bits masked", 32'(irq), 0);
    int_mask = '0;
  endtask

  task automatic t_events;
    clr_all();
    for (int k = 0; k < 5; k++) begin
      ev = 5'(1 << k); tick(); ev = '0;
      chk("R8 event sets its sticky bit", 32'(int_stat[11:7]), (2 << k) - 1);
    end
    clr_we = 1'b1; clr_bits = 12'h080; tick(); clr_we = 1'b0; clr_bits = '0;
    chk("R9 one-bit clear leaves others", 32'(int_stat[11:7]), 32'h1E);
    clr_we = 1'b1; clr_bits = 12'h080; ev = 5'b00001; tick();
    clr_we = 1'b0; clr_bits = '0; ev = '0;
    chk("R9 event wins over clear", 32'(int_stat[7]), 1);
    clr_bits = 12'h800; tick(); clr_bits = '0;
    chk("R9 clear ignored without strobe", 32'(int_stat[11]), 1);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_disabled();
    t_tx();
    t_rx();
    t_srst();
    t_trail();
    t_irq();
    t_events();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule